// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns one pointer event into a five-byte report and queues the bytes for a serial receive channel. An event carries two signed motion deltas and three button states. The first byte of the report is a sync byte that holds the buttons in active-low form. The second byte is the horizontal motion. The third byte is the vertical motion with its sign flipped. Both motion bytes are clamped to the symmetric range -127..127. The last two bytes are always zero.

The bytes are pushed into a byte FIFO, one per cycle, with no gap. Bytes that arrive while the FIFO is full are dropped, and each dropped byte gives a one-cycle pulse. A host drains the FIFO one byte per read strobe. Each read lowers the data-available flag. The flag comes back one cycle later if bytes remain. A read of an empty FIFO returns zero.

Top module: `mouse_pkt_enc`

## Requirements
- R1: Byte 0 is 0x87 with bit2 cleared when left is pressed, bit1 cleared when middle is pressed, and bit0 cleared when right is pressed.
- R2: Byte 1 is dx in two's complement. Values above 127 give 0x7F and values below -127 give 0x81.
- R3: Byte 2 is the negated dy, clamped to -127..127 (0x7F..0x81) in two's complement.
- R4: Bytes 3 and 4 of every report are 0x00.
- R5: The five bytes of one event enter the FIFO on five consecutive cycles, in the order byte 0 to byte 4. An event that arrives while a report is being queued is held. It is queued right after the current report ends, and no report is interleaved with another. A held event that has not yet started is replaced by a newer one.
- R6: A read strobe while the FIFO is empty yields rd_byte = 0x00.
- R7: On the cycle after a read, rx_avail is 0. One cycle later it is 1 if the FIFO still holds bytes.
- R8: A byte pushed while the FIFO holds DEPTH bytes and no read is in progress is discarded, and byte_dropped pulses high for one cycle. The bytes already stored are unchanged.
- R9: Bytes leave the FIFO in the order they entered it. rd_byte updates on the clock edge that samples rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | One-cycle strobe that presents a pointer event |
| evt_dx | input | DW | Signed horizontal delta |
| evt_dy | input | DW | Signed vertical delta |
| btn_left | input | 1 | Left button pressed |
| btn_middle | input | 1 | Middle button pressed |
| btn_right | input | 1 | Right button pressed |
| rd_en | input | 1 | Read strobe for one byte |
| rd_byte | output | 8 | Byte returned by the last read |
| rx_avail | output | 1 | FIFO holds a byte that has not been read |
| byte_dropped | output | 1 | Pulse when a byte is lost to a full FIFO |

## Verification
The bench builds the block with DW = 10 and DEPTH = 8. A delta width of 10 lets the bench drive values such as ±200 and -300, so both clamp limits can be reached. A depth of 8 means two back-to-back events (ten bytes) overfill the FIFO. This exercises the drop path and checks that the two lost bytes are the tail of the second report. Smaller cases check two events in a row, a read of an empty FIFO, and the timing of rx_avail after each read.

// File: rtl/mpk_pkg.sv
package mpk_pkg;

  typedef logic [4:0][7:0] mpk_report_t;

  // Clamp a signed value to -127..127 and return it as a byte
  function automatic logic [7:0] mpk_clip(input logic signed [31:0] v);
    if (v > 32'sd127)       return 8'h7F;
    else if (v < -32'sd127) return 8'h81;
    else                    return v[7:0];
  endfunction

  function automatic logic [7:0] mpk_sync(input logic l, input logic m, input logic r);
    return {5'b10000, ~l, ~m, ~r};
  endfunction

  function automatic mpk_report_t mpk_build(input logic signed [31:0] dx,
                                            input logic signed [31:0] dy,
                                            input logic l, input logic m,
                                            input logic r);
    mpk_report_t p;
    p[0] = mpk_sync(l, m, r);
    p[1] = mpk_clip(dx);
    p[2] = mpk_clip(-dy);
    p[3] = 8'h00;
    p[4] = 8'h00;
    return p;
  endfunction

endpackage

// File: rtl/mpk_framer.sv
module mpk_framer import mpk_pkg::*; #(
  parameter int DW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_valid,
  input  logic signed [DW-1:0] evt_dx,
  input  logic signed [DW-1:0] evt_dy,
  input  logic [2:0]           evt_btn,   // {left, middle, right}
  output logic                 push_o,
  output logic [7:0]           byte_o
);
  localparam int NBYTES = 5;

  mpk_report_t evt_rep, shreg, held_rep, next_rep;
  logic [2:0]  left_q;
  logic        held_v;
  logic        load_now;
  logic signed [31:0] dx32, dy32;

  assign dx32    = 32'(evt_dx);
  assign dy32    = 32'(evt_dy);
  assign evt_rep = mpk_build(dx32, dy32, evt_btn[2], evt_btn[1], evt_btn[0]);

  // a new report may start when idle or on the last byte of the current one
  assign load_now = (left_q <= 3'd1) && (held_v || evt_valid);
  assign next_rep = held_v ? held_rep : evt_rep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      left_q <= '0;
    end else if (load_now) begin
      shreg  <= next_rep;
      left_q <= 3'(NBYTES);
    end else if (left_q != 0) begin
      shreg  <= {8'h00, shreg[4:1]};
      left_q <= left_q - 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_v   <= 1'b0;
      held_rep <= '0;
    end else if (evt_valid && !(load_now && !held_v)) begin
      held_v   <= 1'b1;
      held_rep <= evt_rep;
    end else if (load_now) begin
      held_v   <= 1'b0;
    end
  end

  assign push_o = (left_q != 0);
  assign byte_o = shreg[0];

  // R5
  contiguous_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && left_q > 3'd1) |=> push_o);
  // R1
  sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_now) |=> (byte_o[7:3] == 5'b10000));
  // R5
  held_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_v && left_q == 3'd1) |=> (push_o && byte_o[7:3] == 5'b10000));

endmodule

// File: rtl/mpk_fifo.sv
module mpk_fifo #(
  parameter int DEPTH = 256,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rd_byte_o,
  output logic         avail_o,
  output logic         ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          empty, full, do_pop, do_push, drop_now;

  assign empty    = (count == 0);
  assign full     = (count == CW'(DEPTH));
  assign do_pop   = pop_i && !empty;
  assign do_push  = push_i && (!full || do_pop);
  assign drop_now = push_i && !do_push;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      rd_byte_o <= '0;
      avail_o   <= 1'b0;
      ovf_o     <= 1'b0;
    end else begin
      if (do_push) wptr <= wrap_inc(wptr);
      if (do_pop)  rptr <= wrap_inc(rptr);
      count <= count + CW'(do_push) - CW'(do_pop);
      if (pop_i) rd_byte_o <= empty ? '0 : mem[rptr];
      avail_o <= pop_i ? 1'b0 : !empty;
      ovf_o   <= drop_now;
    end
  end

  // R8
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !pop_i) |=> ovf_o);
  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty) |=> (rd_byte_o == '0));
  // R7
  avail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |=> !avail_o);
  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !do_pop) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc #(
  parameter int DW    = 10,
  parameter int DEPTH = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_valid,
  input  logic signed [DW-1:0] evt_dx,
  input  logic signed [DW-1:0] evt_dy,
  input  logic                 btn_left,
  input  logic                 btn_middle,
  input  logic                 btn_right,
  input  logic                 rd_en,
  output logic [7:0]           rd_byte,
  output logic                 rx_avail,
  output logic                 byte_dropped
);
  logic       pkt_push;
  logic [7:0] pkt_byte;

  mpk_framer #(.DW(DW)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_dx    (evt_dx),
    .evt_dy    (evt_dy),
    .evt_btn   ({btn_left, btn_middle, btn_right}),
    .push_o    (pkt_push),
    .byte_o    (pkt_byte)
  );

  mpk_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (pkt_push),
    .wdata_i   (pkt_byte),
    .pop_i     (rd_en),
    .rd_byte_o (rd_byte),
    .avail_o   (rx_avail),
    .ovf_o     (byte_dropped)
  );

  // R8
  drop_only_on_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_dropped |-> $past(pkt_push));

endmodule

// File: tb/mouse_pkt_enc_test.sv
module mouse_pkt_enc_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 1'b0;
  logic signed [DW-1:0] evt_dx = '0, evt_dy = '0;
  logic btn_left = 1'b0, btn_middle = 1'b0, btn_right = 1'b0;
  logic rd_en = 1'b0;
  logic [7:0] rd_byte;
  logic rx_avail, byte_dropped;

  int n_tests = 0, n_fail = 0, drop_seen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mouse_pkt_enc #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_dx(evt_dx),
    .evt_dy(evt_dy), .btn_left(btn_left), .btn_middle(btn_middle),
    .btn_right(btn_right), .rd_en(rd_en), .rd_byte(rd_byte),
    .rx_avail(rx_avail), .byte_dropped(byte_dropped)
  );

  always @(negedge clk) if (byte_dropped) drop_seen++;

  // independent restatement of the clamp: integer limits then low byte
  function automatic int ref_clamp(input int v);
    int c;
    c = (v >= 128) ? 127 : ((v <= -128) ? -127 : v);
    return c & 255;
  endfunction

  function automatic int ref_sync(input bit l, input bit m, input bit r);
    return 135 - (l ? 4 : 0) - (m ? 2 : 0) - (r ? 1 : 0);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input int dx, input int dy, input bit l, input bit m, input bit r);
    @(negedge clk);
    evt_valid = 1'b1; evt_dx = DW'(dx); evt_dy = DW'(dy);
    btn_left = l; btn_middle = m; btn_right = r;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic pull(output int b, output bit av);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    b  = rd_byte;
    av = rx_avail;
  endtask

  task automatic expect_report(input string tag, input int dx, input int dy,
                               input bit l, input bit m, input bit r);
    int b; bit av;
    pull(b, av); check({tag, " R1 sync"}, b, ref_sync(l, m, r));
    pull(b, av); check({tag, " R2 dx"}, b, ref_clamp(dx));
    pull(b, av); check({tag, " R3 dy"}, b, ref_clamp(-dy));
    pull(b, av); check({tag, " R4 pad3"}, b, 0);
    pull(b, av); check({tag, " R4 pad4"}, b, 0);
  endtask

  task automatic t_reset;
    check("reset rx_avail", int'(rx_avail), 0);
    check("reset rd_byte", int'(rd_byte), 0);
    check("reset byte_dropped", int'(byte_dropped), 0);
  endtask

  task automatic t_single(input int dx, input int dy, input bit l, input bit m, input bit r);
    send(dx, dy, l, m, r);
    repeat (7) @(negedge clk);
    check("R9 avail after event", int'(rx_avail), 1);
    expect_report("single", dx, dy, l, m, r);
  endtask

  task automatic t_avail_timing;
    int b; bit av;
    send(3, 4, 1'b0, 1'b1, 1'b0);
    repeat (7) @(negedge clk);
    pull(b, av);
    check("R7 avail low after read", int'(av), 0);
    @(negedge clk);
    check("R7 avail back with bytes left", int'(rx_avail), 1);
    pull(b, av); pull(b, av); pull(b, av);
    pull(b, av);
    check("R7 last byte read", b, 0);
    @(negedge clk);
    check("R7 avail stays low when empty", int'(rx_avail), 0);
  endtask

  task automatic t_back_to_back;
    send(10, -10, 1'b1, 1'b0, 1'b0);
    send(-20, 20, 1'b0, 1'b0, 1'b1);
    repeat (12) @(negedge clk);
    expect_report("R5 first", 10, -10, 1'b1, 1'b0, 1'b0);
    expect_report("R5 second", -20, 20, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_empty_read;
    int b; bit av;
    pull(b, av);
    check("R6 empty read value", b, 0);
    check("R6 empty read avail", int'(av), 0);
  endtask

  task automatic t_overflow;
    int b; bit av;
    drop_seen = 0;
    send(200, 300, 1'b1, 1'b1, 1'b1);
    send(-1, 1, 1'b0, 1'b0, 1'b0);
    repeat (14) @(negedge clk);
    check("R8 drop pulses", drop_seen, 2);
    expect_report("R8 kept first", 200, 300, 1'b1, 1'b1, 1'b1);
    pull(b, av); check("R8 kept sync", b, ref_sync(1'b0, 1'b0, 1'b0));
    pull(b, av); check("R8 kept dx", b, ref_clamp(-1));
    pull(b, av); check("R8 kept dy", b, ref_clamp(-1));
    check("R8 tail dropped avail", int'(av), 0);
    @(negedge clk);
    check("R8 empty after kept bytes", int'(rx_avail), 0);
    pull(b, av); check("R8 R6 read past end", b, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single(0, 0, 1'b0, 1'b0, 1'b0);        // R1 idle sync 0x87
    t_single(200, 10, 1'b1, 1'b0, 1'b0);     // R2 upper clamp, R3 negation
    t_single(-200, -300, 1'b1, 1'b1, 1'b1);  // R2 lower clamp, R3 upper clamp
    t_single(-5, 200, 1'b0, 1'b1, 1'b1);     // R3 lower clamp
    t_single(127, -127, 1'b0, 1'b0, 1'b1);   // R2 R3 exact limits
    t_avail_timing();
    t_back_to_back();
    t_empty_read();
    t_overflow();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule